// File: doc/BRIEF.md
# Read completion packet splitter

This block takes one read request, given as a byte address and a byte length, and breaks it into a stream of completion descriptors. Each descriptor names a start address and a byte count. Taken together, the descriptors cover the requested byte range exactly once, in ascending address order.

Two rules limit every descriptor. It may carry no more than the maximum payload `MPS` bytes, and it may not cross an address boundary that is a multiple of `MPS`. A request that starts at an unaligned address therefore produces a short first descriptor, which ends at the next aligned boundary. Each later descriptor carries a full payload until the remainder is used up.

Requests arrive on a valid/ready handshake. Descriptors leave on a valid/ready stream with a flag that marks the final descriptor of each request. Only one request is in flight at a time. A downstream completion engine uses the descriptors to build its packets.

Top module: `rd_cpl_splitter`

## Requirements
- R1: While reset is held and after it is released, `cpl_valid` is 0 and `req_ready` is 1.
- R2: A request with a nonzero length is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its first descriptor is valid in the following cycle, and that descriptor's address equals the request address.
- R3: The first descriptor's byte count is min(length, MPS − (address mod MPS)).
- R4: Each later descriptor starts at the address just past the previous one and carries min(remaining, MPS) bytes. The counts of one request sum to its length.
- R5: Every descriptor has a count from 1 to MPS and stays inside one aligned MPS window. Every descriptor except the final one ends exactly on a multiple of MPS.
- R6: `cpl_last` is 1 on the descriptor that brings the remaining count to zero, and 0 on every other descriptor.
- R7: `req_ready` is 0 from the cycle after a nonzero-length request is accepted until the cycle after its final descriptor is taken. No new request is accepted before then.
- R8: While `cpl_valid` is 1 and `cpl_ready` is 0, the address, count and last flag hold their values into the next cycle.
- R9: A request of length 0 is accepted and produces no descriptor. `cpl_valid` stays 0 and `req_ready` stays 1 in the next cycle.
- R10: With MPS = 64, address 0x31121133 and length 202 give exactly four descriptors of 13, 64, 64 and 61 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Request start byte address |
| req_len | input | LEN_W | Request length in bytes |
| cpl_valid | output | 1 | Descriptor present |
| cpl_ready | input | 1 | Consumer takes the descriptor |
| cpl_addr | output | ADDR_W | Descriptor start byte address |
| cpl_bytes | output | log2(MPS)+1 | Descriptor byte count |
| cpl_last | output | 1 | Final descriptor of the request |

## Verification
The first descriptor of a request is due one cycle after the edge that accepts it. Each following descriptor appears in the cycle after the edge on which the previous one is taken. `req_ready` returns one cycle after the edge that takes the final descriptor. A zero-length request leaves the outputs idle in the very next cycle. The reference model updates its queue of expected descriptors on each rising edge and compares every output on the falling edge that follows, so each result is checked in exactly the cycle it is due. This holds under full-rate, stalled and pseudo-random consumer readiness.

// File: rtl/cpl_split_pkg.sv
package cpl_split_pkg;

  // Bytes that fit before the next aligned window edge, capped by what is left.
  function automatic int unsigned chunk_len(int unsigned off, int unsigned remain,
                                            int unsigned mps);
    int unsigned room;
    room = mps - off;
    return (remain < room) ? remain : room;
  endfunction

  // True when the remainder fits entirely in the current window.
  function automatic bit is_final(int unsigned off, int unsigned remain,
                                  int unsigned mps);
    return remain <= (mps - off);
  endfunction

endpackage

// File: rtl/cpl_chunk_calc.sv
module cpl_chunk_calc
  import cpl_split_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int MPS   = 64,
  parameter int OFF_W = 6,
  parameter int CNT_W = 7
) (
  input  logic [OFF_W-1:0] addr_off,
  input  logic [LEN_W-1:0] remain,
  output logic [CNT_W-1:0] chunk,
  output logic             final_chunk
);

  int unsigned off_u;
  int unsigned rem_u;

  assign off_u       = 32'(addr_off);
  assign rem_u       = 32'(remain);
  assign chunk       = CNT_W'(chunk_len(off_u, rem_u, MPS));
  assign final_chunk = is_final(off_u, rem_u, MPS);

endmodule

// File: rtl/cpl_split_track.sv
module cpl_split_track #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              advance,
  input  logic [CNT_W-1:0]  step,
  input  logic              step_final,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  remain
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      cur_addr <= load_addr;
      remain   <= load_len;
    end else if (advance) begin
      cur_addr <= cur_addr + ADDR_W'(step);
      remain   <= remain - LEN_W'(step);
      if (step_final) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/rd_cpl_splitter.sv
module rd_cpl_splitter #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int MPS    = 64,
  localparam int OFF_W = $clog2(MPS),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [ADDR_W-1:0] cpl_addr,
  output logic [CNT_W-1:0]  cpl_bytes,
  output logic              cpl_last
);

  // Named events, observed by the bound checker.
  logic              busy;
  logic              req_fire;
  logic              load;
  logic              cpl_fire;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [CNT_W-1:0]  chunk;
  logic              final_chunk;

  assign req_ready = ~busy;
  assign req_fire  = req_valid & req_ready;
  assign load      = req_fire & (req_len != '0);
  assign cpl_valid = busy;
  assign cpl_fire  = cpl_valid & cpl_ready;

  cpl_chunk_calc #(
    .LEN_W(LEN_W), .MPS(MPS), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) calc_i (
    .addr_off   (cur_addr[OFF_W-1:0]),
    .remain     (remain),
    .chunk      (chunk),
    .final_chunk(final_chunk)
  );

  cpl_split_track #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) track_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (req_addr),
    .load_len  (req_len),
    .advance   (cpl_fire),
    .step      (chunk),
    .step_final(final_chunk),
    .busy      (busy),
    .cur_addr  (cur_addr),
    .remain    (remain)
  );

  assign cpl_addr  = cur_addr;
  assign cpl_bytes = chunk;
  assign cpl_last  = final_chunk;

endmodule

// File: rtl/cpl_split_chk.sv
module cpl_split_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int MPS    = 64,
  localparam int OFF_W = $clog2(MPS),
  localparam int CNT_W = OFF_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_fire,
  input logic              load,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic              cpl_fire,
  input logic [ADDR_W-1:0] cpl_addr,
  input logic [CNT_W-1:0]  cpl_bytes,
  input logic              cpl_last
);

  logic [OFF_W-1:0] end_off;
  logic [CNT_W:0]   span;

  assign end_off = cpl_addr[OFF_W-1:0] + OFF_W'(cpl_bytes);
  assign span    = (CNT_W+1)'(cpl_addr[OFF_W-1:0]) + (CNT_W+1)'(cpl_bytes);

  // R2
  p_start_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cpl_valid && (cpl_addr == $past(req_addr)));

  // R4
  p_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_fire && !cpl_last |=> cpl_valid &&
      (cpl_addr == $past(cpl_addr) + ADDR_W'($past(cpl_bytes))));

  // R5
  p_size_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (cpl_bytes != '0) && (span <= (CNT_W+1)'(MPS)));

  // R5
  p_mid_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_last |-> end_off == '0);

  // R7
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !req_ready);

  // R7
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_fire && cpl_last |=> req_ready && !cpl_valid);

  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_addr) &&
      $stable(cpl_bytes) && $stable(cpl_last));

  // R9
  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && (req_len == '0) |=> !cpl_valid && req_ready);

endmodule

bind rd_cpl_splitter cpl_split_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS(MPS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_fire (req_fire),
  .load     (load),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .req_len  (req_len),
  .cpl_valid(cpl_valid),
  .cpl_ready(cpl_ready),
  .cpl_fire (cpl_fire),
  .cpl_addr (cpl_addr),
  .cpl_bytes(cpl_bytes),
  .cpl_last (cpl_last)
);

// File: tb/rd_cpl_splitter_tb_top.sv
module rd_cpl_splitter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam int MPS    = 64;
  localparam int CNT_W  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic cpl_valid;
  logic cpl_ready = 1'b1;
  logic [ADDR_W-1:0] cpl_addr;
  logic [CNT_W-1:0]  cpl_bytes;
  logic cpl_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_cpl_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS(MPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .cpl_valid(cpl_valid),
    .cpl_ready(cpl_ready), .cpl_addr(cpl_addr), .cpl_bytes(cpl_bytes),
    .cpl_last(cpl_last));

  typedef struct {
    longint unsigned addr;
    int              bytes;
    bit              last;
    bit              first;
  } exp_t;

  exp_t q[$];
  int   got_log[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  int   ready_mode = 0;   // 0 always, 1 pseudo-random, 2 stalled
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int unsigned next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  // Reference model: expected chunks built by walking window edges.
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
    end else begin
      if (q.size() != 0 && cpl_ready) begin
        got_log.push_back(q[0].bytes);
        void'(q.pop_front());
      end else if (q.size() == 0 && req_valid && req_len != 0) begin
        longint unsigned a, e, nb;
        bit first;
        a = req_addr;
        e = a + req_len;
        first = 1;
        while (a < e) begin
          exp_t d;
          nb = (a / MPS + 1) * MPS;
          if (nb > e) nb = e;
          d.addr = a & 64'hFFFF_FFFF;
          d.bytes = int'(nb - a);
          d.last = (nb == e);
          d.first = first;
          q.push_back(d);
          first = 0;
          a = nb;
        end
      end
    end
  end

  // Consumer readiness, driven just after each rising edge.
  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0: cpl_ready = 1'b1;
      1: cpl_ready = next_rand()[9];
      default: cpl_ready = 1'b0;
    endcase
  end

  // Cycle-by-cycle comparison on the falling edge.
  logic              prev_stall = 1'b0;
  logic [ADDR_W-1:0] prev_addr;
  logic [CNT_W-1:0]  prev_bytes;
  logic              prev_last;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cpl_valid == (q.size() != 0), "R2", "cpl_valid", cpl_valid, q.size() != 0);
      chk(req_ready == (q.size() == 0), "R7", "req_ready", req_ready, q.size() == 0);
      if (cpl_valid && q.size() != 0) begin
        int off;
        off = int'(cpl_addr % MPS);
        chk(cpl_addr == q[0].addr[31:0], q[0].first ? "R2" : "R4", "cpl_addr",
            cpl_addr, q[0].addr);
        chk(int'(cpl_bytes) == q[0].bytes, q[0].first ? "R3" : "R4", "cpl_bytes",
            cpl_bytes, q[0].bytes);
        chk(cpl_last == q[0].last, "R6", "cpl_last", cpl_last, q[0].last);
        chk(cpl_bytes != 0 && off + int'(cpl_bytes) <= MPS, "R5", "window span",
            off + int'(cpl_bytes), MPS);
        if (!cpl_last)
          chk((off + int'(cpl_bytes)) % MPS == 0, "R5", "mid chunk end offset",
              (off + int'(cpl_bytes)) % MPS, 0);
      end
      if (prev_stall) begin
        chk(cpl_valid && cpl_addr == prev_addr && cpl_bytes == prev_bytes &&
            cpl_last == prev_last, "R8", "held descriptor addr", cpl_addr, prev_addr);
      end
      prev_stall = cpl_valid && !cpl_ready;
      prev_addr  = cpl_addr;
      prev_bytes = cpl_bytes;
      prev_last  = cpl_last;
    end
  end

  task automatic send_req(longint unsigned a, int len);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = a[31:0];
    req_len   = LEN_W'(len);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || !req_ready);
  endtask

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(cpl_valid == 1'b0, "R1", "cpl_valid in reset", cpl_valid, 0);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpl_valid == 1'b0 && req_ready == 1'b1, "R1", "idle after reset", cpl_valid, 0);

    // R10: the worked example at full rate
    got_log.delete();
    send_req(64'h3112_1133, 202);
    wait_idle();
    chk(got_log.size() == 4, "R10", "chunk count", got_log.size(), 4);
    if (got_log.size() == 4) begin
      chk(got_log[0] == 13, "R10", "chunk0", got_log[0], 13);
      chk(got_log[1] == 64, "R10", "chunk1", got_log[1], 64);
      chk(got_log[2] == 64, "R10", "chunk2", got_log[2], 64);
      chk(got_log[3] == 61, "R10", "chunk3", got_log[3], 61);
    end

    // R9: zero length request leaves the output idle
    send_req(64'h80, 0);
    @(negedge clk);
    chk(cpl_valid == 1'b0, "R9", "cpl_valid after zero len", cpl_valid, 0);
    chk(req_ready == 1'b1, "R9", "req_ready after zero len", req_ready, 1);

    // Directed boundary shapes, back to back (R7 blocking)
    send_req(64'h1000, 64);
    send_req(64'h1000, 200);
    send_req(64'h3F, 1);
    send_req(64'h3F, 2);
    send_req(64'hFFFF_FFF0, 40);
    wait_idle();

    // R8: stall mid-request, then release
    send_req(64'h205, 150);
    ready_mode = 2;
    repeat (6) @(posedge clk);
    ready_mode = 0;
    wait_idle();

    // Max length under pseudo-random backpressure
    ready_mode = 1;
    send_req(64'h40, 4095);
    for (int i = 0; i < 30; i++) begin
      int unsigned a, l;
      a = next_rand();
      l = (next_rand() % 300) + 1;
      send_req(longint'(a), int'(l));
    end
    wait_idle();
    ready_mode = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule